// File: doc/BRIEF.md
# Burst Flash Read Controller

This block sits on the host side of a synchronous burst NOR flash and fetches a block of 16-bit words. A request carries a start address and a two-bit size code selecting 8, 16 or 32 words. The controller opens the transfer with a single address strobe while the chip select is active. It then turns on the output enable and waits for the device's ready line. From then on it takes one word on each rising edge at which the line reports ready.

Each captured word leaves on a simple stream made of data, a valid strobe and a last flag. A done pulse marks the end of the transfer. Because the controller paces itself on the ready line, the same logic works with any device wait-state setting. A programmable ready polarity matches the device configuration. A programmable watchdog on the ready line aborts a transfer that stalls and reports an error. After every transfer the chip is deselected, and one idle cycle passes before the next request is taken.

Top module: `bflash_rd_ctrl`

## Requirements
- R1: After reset, req_ready is 1. fl_ce_n, fl_avd_n and fl_oe_n are 1. fl_clk_en, out_valid, out_last, done and err are 0.
- R2: When req_valid is high with req_ready high at a rising edge, the next cycle drives fl_avd_n=0, fl_ce_n=0, fl_oe_n=1 and fl_adr equal to req_addr. fl_avd_n is low for exactly one cycle, and req_ready is 0.
- R3: In the cycle after the address cycle, and until the transfer ends, fl_oe_n=0, fl_ce_n=0 and fl_avd_n=1.
- R4: req_len selects the word count. Code 0 selects 8, code 1 selects 16, code 2 selects 32, and code 3 selects 8.
- R5: A word is taken from fl_dq only at a rising edge where fl_rdy equals cfg_rdy_high. The word appears on out_data with out_valid=1 in the cycle after that edge. Edges where the line is at the other level produce no word.
- R6: Words are delivered in the order presented, one per ready edge, with no further address strobe during the transfer.
- R7: The final word of the count carries out_last=1, and done=1 in the same cycle.
- R8: With cfg_timeout nonzero, if fl_rdy is not ready at cfg_timeout consecutive rising edges of the transfer, the transfer aborts. err and done pulse for one cycle, with out_valid=0 and out_last=0 in that cycle, and no further word is delivered.
- R9: cfg_timeout=0 disables the abort, so any number of not-ready edges is tolerated.
- R10: In the cycle where done is high, fl_ce_n=1, fl_oe_n=1, fl_clk_en=0 and req_ready=0. In the following cycle req_ready returns to 1.
- R11: req_valid raised while req_ready is 0 is ignored: no address strobe results from it.
- R12: fl_clk_en is 1 from the address cycle through the cycle of the last sampling edge, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and flash clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Word address of the first word |
| req_len | input | 2 | Size code (0:8, 1:16, 2:32, 3:8) |
| cfg_rdy_high | input | 1 | Level of fl_rdy that means ready |
| cfg_timeout | input | TMO_W | Not-ready edges tolerated before abort; 0 disables |
| fl_clk_en | output | 1 | Enable for the flash clock |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_avd_n | output | 1 | Address strobe, active low |
| fl_adr | output | ADDR_W | Address to the flash |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rdy | input | 1 | Flash ready line |
| fl_dq | input | DATA_W | Flash read data |
| out_valid | output | 1 | out_data holds a captured word |
| out_data | output | DATA_W | Captured word |
| out_last | output | 1 | Word is the last of the transfer |
| done | output | 1 | Transfer finished (normal or aborted) |
| err | output | 1 | Transfer aborted by the ready timeout |

## Verification
A corrupt word counter shows up at the ports within one transfer. The last flag and done move away from the requested count, and the number of valid strobes differs from 8, 16 or 32. A state machine stuck or skipping a state shows up as a missing or doubled address strobe, or as an output enable that is low outside a transfer. It also shows up as a missing idle cycle before req_ready returns, and each of these is visible within two cycles of the fault. A wrong timeout count moves the abort by exactly one edge. The bench checks this at the boundary where the latency equals the limit and where it is one less.

// File: rtl/bflash_pkg.sv
package bflash_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_BURST = 2'd2,
      ST_GAP   = 2'd3
   } bf_state_e;

   localparam int unsigned BF_MAX_BEATS = 32;
   localparam int unsigned BF_CNT_W     = $clog2(BF_MAX_BEATS + 1);

   function automatic logic [BF_CNT_W-1:0] bf_beats(input logic [1:0] code);
      logic [BF_CNT_W-1:0] n;
      case (code)
         2'd1:    n = BF_CNT_W'(16);
         2'd2:    n = BF_CNT_W'(32);
         default: n = BF_CNT_W'(8);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/bflash_tmo.sv
module bflash_tmo #(
   parameter int unsigned TMO_W  = 8,
   parameter bit          TMO_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ready,
   input  logic [TMO_W-1:0] limit,
   output logic             expired
);

   generate
      if (TMO_EN) begin : g_tmo
         logic [TMO_W-1:0] miss_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               miss_q <= '0;
            else if (!run || ready)
               miss_q <= '0;
            else if (miss_q != {TMO_W{1'b1}})
               miss_q <= miss_q + TMO_W'(1);
         end

         assign expired = run && !ready && (limit != '0) &&
                          (miss_q == limit - TMO_W'(1));

         p_tmo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (limit == '0) |-> !expired)
            else $error("timeout fired while disabled");
      end else begin : g_no_tmo
         logic unused_tmo;
         assign unused_tmo = ^{limit, ready, run, clk, rst_n};
         assign expired    = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/bflash_beat_ctr.sv
module bflash_beat_ctr #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  beats,
   input  logic              capture,
   input  logic [DATA_W-1:0] din,
   output logic              final_beat,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last
);

   logic [CNT_W-1:0] cnt_q;

   assign final_beat = capture && (cnt_q == beats - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= '0;
      else if (capture)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= capture;
         out_last  <= final_beat;
         if (capture)
            out_data <= din;
      end
   end

   p_beat_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      capture |-> (cnt_q < beats))
      else $error("word counter past requested count");

endmodule

// File: rtl/bflash_rd_ctrl.sv
module bflash_rd_ctrl
   import bflash_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned TMO_W  = 8,
   parameter bit          TMO_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_len,
   input  logic              cfg_rdy_high,
   input  logic [TMO_W-1:0]  cfg_timeout,
   output logic              fl_clk_en,
   output logic              fl_ce_n,
   output logic              fl_avd_n,
   output logic [ADDR_W-1:0] fl_adr,
   output logic              fl_oe_n,
   input  logic              fl_rdy,
   input  logic [DATA_W-1:0] fl_dq,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_last,
   output logic              done,
   output logic              err
);

   localparam int unsigned CNT_W = BF_CNT_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
      if (TMO_W < 1 || TMO_W > 31) begin : g_bad_tmo
         $error("TMO_W out of range");
      end
   endgenerate

   bf_state_e         state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  beats_q;
   logic              accept, rdy_act, in_burst, capture;
   logic              final_beat, expired;

   assign rdy_act  = (fl_rdy == cfg_rdy_high);
   assign in_burst = (state_q == ST_BURST);
   assign capture  = in_burst && rdy_act;
   assign accept   = req_valid && (state_q == ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (accept) state_d = ST_ADDR;
         ST_ADDR:  state_d = ST_BURST;
         ST_BURST: if (final_beat || expired) state_d = ST_GAP;
         ST_GAP:   state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         beats_q <= CNT_W'(8);
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            addr_q  <= req_addr;
            beats_q <= bf_beats(req_len);
         end
         done <= final_beat || expired;
         err  <= expired;
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign fl_ce_n   = !((state_q == ST_ADDR) || in_burst);
   assign fl_avd_n  = (state_q != ST_ADDR);
   assign fl_oe_n   = !in_burst;
   assign fl_clk_en = (state_q == ST_ADDR) || in_burst;
   assign fl_adr    = addr_q;

   bflash_tmo #(
      .TMO_W  (TMO_W),
      .TMO_EN (TMO_EN)
   ) u_tmo (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_burst),
      .ready   (rdy_act),
      .limit   (cfg_timeout),
      .expired (expired)
   );

   bflash_beat_ctr #(
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
   ) u_beats (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (accept),
      .beats      (beats_q),
      .capture    (capture),
      .din        (fl_dq),
      .final_beat (final_beat),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_last   (out_last)
   );

   p_avd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_avd_n |=> fl_avd_n)
      else $error("address strobe longer than one cycle");

   p_avd_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_avd_n |-> (!fl_ce_n && fl_oe_n))
      else $error("address strobe without select or with output enabled");

   p_oe_follows_avd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_avd_n |=> (!fl_oe_n && !fl_ce_n))
      else $error("output enable not asserted after address cycle");

   p_valid_on_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(fl_rdy == cfg_rdy_high))
      else $error("word taken while not ready");

   p_last_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (done && out_valid && !err))
      else $error("last flag without done");

   p_err_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && !out_valid && !out_last))
      else $error("error pulse malformed");

   p_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fl_ce_n && fl_oe_n && !req_ready && !fl_clk_en))
      else $error("flash not released at done");

   p_ready_back_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> req_ready)
      else $error("no return to idle after gap");

   p_clk_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_oe_n || !fl_avd_n) |-> fl_clk_en)
      else $error("flash clock gated during transfer");

endmodule

// File: tb/bflash_rd_ctrl_bench.sv
module bflash_rd_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_len = '0;
   logic          cfg_rdy_high = 1'b1;
   logic [TW-1:0] cfg_timeout = '0;
   logic          fl_clk_en, fl_ce_n, fl_avd_n, fl_oe_n;
   logic [AW-1:0] fl_adr;
   logic          fl_rdy = 1'b0;
   logic [DW-1:0] fl_dq = '0;
   logic          out_valid, out_last, done, err;
   logic [DW-1:0] out_data;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bflash_rd_ctrl u_bflash_rd_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len),
      .cfg_rdy_high(cfg_rdy_high), .cfg_timeout(cfg_timeout),
      .fl_clk_en(fl_clk_en), .fl_ce_n(fl_ce_n), .fl_avd_n(fl_avd_n),
      .fl_adr(fl_adr), .fl_oe_n(fl_oe_n), .fl_rdy(fl_rdy), .fl_dq(fl_dq),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .done(done), .err(err)
   );

   function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
      return (a[15:0] * 16'h9E37) ^ {a[23:16], a[23:16]} ^ 16'h5A5A;
   endfunction

   function automatic int beats_of(input int code);
      case (code)
         1: return 16;
         2: return 32;
         default: return 8;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // flash model: decisions at the falling edge, sampled by the DUT at the rising edge
   int            m_lat = 0;
   int            m_stall = 0;
   int            m_left = 0;
   logic [AW-1:0] m_base = '0;
   int            m_idx = 0;
   bit            m_prev = 1'b0;

   always @(negedge clk) begin
      bit act;
      act = 1'b0;
      if (!fl_avd_n && !fl_ce_n) begin
         m_base = fl_adr;
         m_idx  = 0;
         m_left = m_lat;
         m_prev = 1'b0;
      end else if (!fl_oe_n && !fl_ce_n) begin
         if (m_left > 0)
            m_left--;
         else if (m_prev && m_stall != 0 && ($urandom % 100) < m_stall)
            act = 1'b0;
         else begin
            act   = 1'b1;
            fl_dq = word_at(m_base + AW'(m_idx));
            m_idx++;
         end
         m_prev = act;
      end
      fl_rdy = act ? cfg_rdy_high : ~cfg_rdy_high;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   task automatic run_burst(input logic [AW-1:0] a, input int code, input int lat,
                            input int stall, input logic pol, input int tmo, input bit inject);
      int  exp_n, n, cycles, avd_extra, clk_bad;
      bit  exp_err;
      exp_n   = beats_of(code);
      exp_err = (tmo != 0) && (lat >= tmo);
      m_lat = lat; m_stall = stall;
      @(negedge clk);
      cfg_rdy_high = pol;
      cfg_timeout  = TW'(tmo);
      req_valid = 1'b1; req_addr = a; req_len = 2'(code);
      @(negedge clk);
      req_valid = 1'b0;
      // R2: single address cycle with the request address
      chk(!fl_avd_n && !fl_ce_n && fl_oe_n && !req_ready, "R2 strobe",
          {fl_avd_n, fl_ce_n, fl_oe_n, req_ready}, 4'b0010);
      chk(fl_adr == a, "R2 address", fl_adr, a);
      chk(fl_clk_en == 1'b1, "R12 clk_en in address cycle", fl_clk_en, 1);
      @(negedge clk);
      // R3: output phase
      chk(fl_avd_n && !fl_oe_n && !fl_ce_n, "R3 output phase",
          {fl_avd_n, fl_oe_n, fl_ce_n}, 3'b100);
      n = 0; cycles = 0; avd_extra = 0; clk_bad = 0;
      while (!done && cycles < 600) begin
         if (inject) req_valid = (cycles == 3);
         if (!fl_avd_n) avd_extra++;
         if (!fl_clk_en) clk_bad++;
         if (out_valid) begin
            chk(out_data == word_at(a + AW'(n)), "R6 word order", out_data, word_at(a + AW'(n)));
            n++;
            chk(out_last == (n == exp_n), "R7 last flag", out_last, (n == exp_n));
         end
         @(negedge clk);
         cycles++;
      end
      req_valid = 1'b0;
      chk(cycles < 600, "R5 transfer completes", cycles, 600);
      if (out_valid) n++;
      chk(err == exp_err, "R8 R9 error flag", err, exp_err);
      chk(n == (exp_err ? 0 : exp_n), "R4 word count", n, exp_err ? 0 : exp_n);
      chk(out_last == !exp_err, "R7 last at done", out_last, !exp_err);
      chk(avd_extra == 0, "R6 no extra strobe", avd_extra, 0);
      chk(clk_bad == 0, "R12 clk_en during transfer", clk_bad, 0);
      chk(fl_ce_n && fl_oe_n && !req_ready && !fl_clk_en, "R10 release at done",
          {fl_ce_n, fl_oe_n, req_ready, fl_clk_en}, 4'b1100);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready after gap", req_ready, 1);
      if (inject) begin
         for (int k = 0; k < 3; k++) begin
            chk(fl_avd_n == 1'b1, "R11 busy request ignored", fl_avd_n, 1);
            @(negedge clk);
         end
      end
   endtask

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(negedge clk);
      // R1: reset values
      chk(req_ready && fl_ce_n && fl_avd_n && fl_oe_n && !fl_clk_en &&
          !out_valid && !out_last && !done && !err, "R1 reset state",
          {req_ready, fl_ce_n, fl_avd_n, fl_oe_n, fl_clk_en, out_valid, out_last, done, err},
          9'b111100000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);

      run_burst(24'h001000, 0, 3, 0, 1'b1, 0, 1'b0);   // R4 eight words, R5 high polarity
      run_burst(24'h0A0F00, 1, 7, 0, 1'b0, 0, 1'b0);   // R4 sixteen, R5 low polarity
      run_burst(24'h123456, 2, 0, 30, 1'b1, 0, 1'b0);  // R4 thirty-two, R5 stalls
      run_burst(24'hFFFFFC, 3, 2, 0, 1'b0, 0, 1'b0);   // R4 code 3 is eight
      run_burst(24'h000200, 0, 4, 0, 1'b1, 5, 1'b0);   // R8 latency one below limit
      run_burst(24'h000300, 0, 5, 0, 1'b1, 5, 1'b0);   // R8 latency equal to limit aborts
      run_burst(24'h000400, 1, 1, 0, 1'b0, 1, 1'b0);   // R8 smallest limit
      run_burst(24'h000500, 0, 20, 0, 1'b1, 0, 1'b0);  // R9 disabled
      run_burst(24'h000600, 1, 2, 0, 1'b1, 0, 1'b1);   // R11 request while busy

      for (int i = 0; i < 24; i++) begin
         logic [AW-1:0] ra;
         int rc, rl, rs, rt;
         ra = AW'($urandom);
         rc = int'($urandom % 4);
         rl = int'($urandom % 15);
         rs = ($urandom % 2) ? 25 : 0;
         rt = ($urandom % 3 == 0) ? 0 : 2 + int'($urandom % 11);
         run_burst(ra, rc, rl, rs, 1'($urandom), rt, 1'($urandom % 4 == 0));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule